// File: doc/BRIEF.md
# Parallel Camera Pixel Capture Unit

This block takes the 8-bit output of a parallel image sensor, together with its pixel clock and its line and frame sync lines, and turns the valid pixel bytes into 32-bit words for the write port of a downstream FIFO. All sensor lines are brought into the fast system clock domain through two-flop synchronizers. The pixel clock is edge-detected there to produce one sample per pixel. Bytes outside the active window (line or frame blanking) are discarded, so only image bytes are packed.

Software-facing settings arrive as plain configuration inputs. They select the sampling edge, the active level of each sync line, whether capture must wait for a fresh frame boundary, the byte lane order inside a word, and a capture enable. The block marks the start and the end of each frame with one-cycle flags. At the end of a frame it writes any incomplete word, padded with zeros.

The system clock must run at least four times faster than the pixel clock.

Top module: `pixcap_top`

## Requirements
- R1: With `cfg_fall_edge` = 0 a byte is sampled on the rising edge of `cam_pclk`; with 1 it is sampled on the falling edge. The other edge never takes a byte.
- R2: With `cfg_hs_low` = 0 the line sync is active high, and with 1 it is active low. `cfg_vs_low` sets the frame sync in the same way.
- R3: A byte is accepted only when both sync lines are at their active levels on the sampling edge. Bytes sampled during line or frame blanking never reach `wr_data`.
- R4: With `cfg_wait_frame` = 1, no byte is accepted until an inactive-to-active frame sync transition has been seen after enable. Bytes of a frame already in progress at enable are dropped, and its end raises no `frame_end`.
- R5: With `cfg_wait_frame` = 0, capture starts with the first qualifying byte after enable.
- R6: Line sync may toggle between single pixels. Each pixel is qualified on its own line-sync level, and a line-sync toggle never raises `frame_end` or flushes a word.
- R7: Every fourth accepted byte completes a word, and `wr_en` pulses for one cycle. With `cfg_swap_order` = 0 the first byte sits in bits [7:0] and the fourth in [31:24]. With 1 the first byte sits in [31:24] and the fourth in [7:0].
- R8: When frame sync goes inactive during capture, `frame_end` pulses for one cycle. If one to three bytes are pending, they are written in that same cycle, and the unfilled lanes are zero.
- R9: `frame_start` pulses for one cycle on each inactive-to-active frame sync transition seen while enabled. It never coincides with `frame_end`.
- R10: When `cfg_enable` is low, all outputs are zero from the next cycle. Clearing it discards any pending bytes and the frame-armed state. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cam_pclk | input | 1 | Sensor pixel clock |
| cam_data | input | 8 | Sensor pixel byte |
| cam_hs | input | 1 | Line sync from the sensor |
| cam_vs | input | 1 | Frame sync from the sensor |
| cfg_enable | input | 1 | Capture enable |
| cfg_fall_edge | input | 1 | 1: sample on the falling pixel clock edge |
| cfg_hs_low | input | 1 | 1: line sync is active low |
| cfg_vs_low | input | 1 | 1: frame sync is active low |
| cfg_wait_frame | input | 1 | 1: start capture only at a new frame |
| cfg_swap_order | input | 1 | 1: first byte into the top lane |
| wr_data | output | 32 | Packed word to the FIFO |
| wr_en | output | 1 | One-cycle write strobe for wr_data |
| frame_start | output | 1 | One-cycle flag at frame sync activation |
| frame_end | output | 1 | One-cycle flag at frame sync deactivation |

## Verification
A pixel-clock edge applied at the pins between system clock edges reaches the second synchronizer stage on the second rising clock edge. The resulting word, strobe or frame flag is registered on the third. The bench holds each pixel for eight system cycles and moves the data two cycles before the sampling edge, so every result lands inside the pixel period that produced it. A monitor samples the outputs on the falling clock edge and records every write and flag. Each scenario compares those records once its frame has finished, and a decoy byte sits on the non-sampling edge so a wrong edge choice is visible.

// File: rtl/pixcap_pkg.sv
package pixcap_pkg;

    // State of the sync qualification stage
    typedef struct packed {
        logic pclk_prev;   // last synchronized pixel clock level
        logic vs_prev;     // frame sync activity at the previous sample
        logic primed;      // at least one sample seen since enable
        logic armed;       // capture allowed
    } qual_state_t;

endpackage

// File: rtl/pixcap_sync.sv
module pixcap_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stage_d;
    logic [STAGES-1:0][W-1:0] stage_q;

    assign stage_d[0] = din;
    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_chain
            assign stage_d[g] = stage_q[g-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pixcap_qual.sv
module pixcap_qual
    import pixcap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic fall_edge,
    input  logic hs_low,
    input  logic vs_low,
    input  logic wait_frame,
    input  logic pclk_s,
    input  logic hs_s,
    input  logic vs_s,
    output logic accept,
    output logic flush,
    output logic start
);
    qual_state_t st_d, st_q;
    logic smp, hs_act, vs_act, vs_rise, vs_fall, may_cap;

    always_comb begin
        st_d = st_q;
        // sample enable from the chosen pixel clock edge
        smp = en & (fall_edge ? (st_q.pclk_prev & ~pclk_s)
                              : (~st_q.pclk_prev & pclk_s));
        hs_act  = hs_s ^ hs_low;
        vs_act  = vs_s ^ vs_low;
        vs_rise = smp & st_q.primed & vs_act & ~st_q.vs_prev;
        vs_fall = smp & st_q.primed & ~vs_act & st_q.vs_prev;
        may_cap = st_q.armed | ~wait_frame | vs_rise;

        accept = smp & hs_act & vs_act & may_cap;
        flush  = vs_fall & (st_q.armed | ~wait_frame);
        start  = vs_rise;

        st_d.pclk_prev = pclk_s;
        if (smp) st_d.vs_prev = vs_act;
        if (!en) begin
            st_d.primed = 1'b0;
            st_d.armed  = 1'b0;
        end else begin
            st_d.primed = st_q.primed | smp;
            if (!wait_frame || vs_rise) st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pixcap_pack.sv
module pixcap_pack #(
    parameter int PIX_W      = 8,
    parameter int WORD_BYTES = 4,
    localparam int WORD_W    = PIX_W * WORD_BYTES,
    localparam int CW        = $clog2(WORD_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              swap,
    input  logic              accept,
    input  logic              flush,
    input  logic              start,
    input  logic [PIX_W-1:0]  pix,
    output logic [WORD_W-1:0] wr_data,
    output logic              wr_en,
    output logic              frame_start,
    output logic              frame_end
);
    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic [WORD_W-1:0] acc;
        logic [WORD_W-1:0] wdata;
        logic              wen;
        logic              fs;
        logic              fe;
    } pack_state_t;

    pack_state_t st_d, st_q;
    logic [CW-1:0]     lane;
    logic [WORD_W-1:0] merged;

    always_comb begin
        st_d       = st_q;
        st_d.wen   = 1'b0;
        st_d.fs    = start;
        st_d.fe    = flush;
        lane       = swap ? (CW'(WORD_BYTES - 1) - st_q.cnt) : st_q.cnt;
        merged     = st_q.acc;
        merged[lane*PIX_W +: PIX_W] = pix;

        if (!en) begin
            st_d = '0;
        end else if (accept) begin
            if (st_q.cnt == CW'(WORD_BYTES - 1)) begin
                st_d.wdata = merged;
                st_d.wen   = 1'b1;
                st_d.acc   = '0;
                st_d.cnt   = '0;
            end else begin
                st_d.acc = merged;
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (flush && st_q.cnt != '0) begin
            st_d.wdata = st_q.acc;   // unfilled lanes are still zero
            st_d.wen   = 1'b1;
            st_d.acc   = '0;
            st_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_data     = st_q.wdata;
    assign wr_en       = st_q.wen;
    assign frame_start = st_q.fs;
    assign frame_end   = st_q.fe;
endmodule

// File: rtl/pixcap_top.sv
module pixcap_top #(
    parameter int PIX_W       = 8,
    parameter int WORD_BYTES  = 4,
    parameter int SYNC_STAGES = 2,
    localparam int WORD_W     = PIX_W * WORD_BYTES,
    localparam int SYNC_W     = PIX_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cam_pclk,
    input  logic [PIX_W-1:0]  cam_data,
    input  logic              cam_hs,
    input  logic              cam_vs,
    input  logic              cfg_enable,
    input  logic              cfg_fall_edge,
    input  logic              cfg_hs_low,
    input  logic              cfg_vs_low,
    input  logic              cfg_wait_frame,
    input  logic              cfg_swap_order,
    output logic [WORD_W-1:0] wr_data,
    output logic              wr_en,
    output logic              frame_start,
    output logic              frame_end
);
    logic [SYNC_W-1:0] raw_bus, sync_bus;
    logic              pclk_s, hs_s, vs_s;
    logic [PIX_W-1:0]  data_s;
    logic              accept, flush, start;

    assign raw_bus = {cam_pclk, cam_hs, cam_vs, cam_data};

    pixcap_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_bus),
        .dout (sync_bus)
    );

    assign {pclk_s, hs_s, vs_s, data_s} = sync_bus;

    pixcap_qual u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_enable),
        .fall_edge (cfg_fall_edge),
        .hs_low    (cfg_hs_low),
        .vs_low    (cfg_vs_low),
        .wait_frame(cfg_wait_frame),
        .pclk_s    (pclk_s),
        .hs_s      (hs_s),
        .vs_s      (vs_s),
        .accept    (accept),
        .flush     (flush),
        .start     (start)
    );

    pixcap_pack #(.PIX_W(PIX_W), .WORD_BYTES(WORD_BYTES)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cfg_enable),
        .swap       (cfg_swap_order),
        .accept     (accept),
        .flush      (flush),
        .start      (start),
        .pix        (data_s),
        .wr_data    (wr_data),
        .wr_en      (wr_en),
        .frame_start(frame_start),
        .frame_end  (frame_end)
    );
endmodule

// File: rtl/pixcap_chk.sv
module pixcap_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_enable,
    input logic wr_en,
    input logic frame_start,
    input logic frame_end
);
    // R10
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (!wr_en && !frame_start && !frame_end));

    // R9
    start_end_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_start && frame_end));

    // R7
    write_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R9
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R8
    end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);
endmodule

bind pixcap_top pixcap_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .wr_en      (wr_en),
    .frame_start(frame_start),
    .frame_end  (frame_end)
);

// File: tb/tb_pixcap_top.sv
module tb_pixcap_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cam_pclk = 1'b0;
    logic [7:0]  cam_data = '0;
    logic        cam_hs = 1'b0, cam_vs = 1'b0;
    logic        cfg_enable = 1'b0, cfg_fall_edge = 1'b0;
    logic        cfg_hs_low = 1'b0, cfg_vs_low = 1'b0;
    logic        cfg_wait_frame = 1'b0, cfg_swap_order = 1'b0;
    logic [31:0] wr_data;
    logic        wr_en, frame_start, frame_end;

    int n_chk = 0, n_fail = 0;
    int fs_cnt = 0, fe_cnt = 0;
    logic [31:0] words[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pixcap_top dut (.*);

    always @(negedge clk) begin
        if (wr_en)       words.push_back(wr_data);
        if (frame_start) fs_cnt++;
        if (frame_end)   fe_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // one pixel: decoy on the non-sampling edge, real byte on the sampling edge
    task automatic pix(input logic [7:0] v, input logic h, input logic vv);
        cam_pclk = cfg_fall_edge;
        cam_data = 8'hA5;
        repeat (2) @(negedge clk);
        cam_data = v;
        cam_hs   = h ^ cfg_hs_low;
        cam_vs   = vv ^ cfg_vs_low;
        repeat (2) @(negedge clk);
        cam_pclk = ~cfg_fall_edge;
        repeat (4) @(negedge clk);
    endtask

    task automatic setup(input logic fe, input logic hl, input logic vl,
                         input logic wt, input logic sw);
        @(negedge clk);
        cfg_enable = 1'b0;
        repeat (4) @(negedge clk);
        cfg_fall_edge = fe; cfg_hs_low = hl; cfg_vs_low = vl;
        cfg_wait_frame = wt; cfg_swap_order = sw;
        cam_pclk = ~fe;
        cam_hs = hl; cam_vs = vl;
        repeat (4) @(negedge clk);
        words.delete(); fs_cnt = 0; fe_cnt = 0;
        cfg_enable = 1'b1;
    endtask

    task automatic four(input logic [31:0] b);
        for (int i = 0; i < 4; i++) pix(b[i*8 +: 8], 1'b1, 1'b1);
    endtask

    task automatic t_reset();
        chk("R10 reset wr_en", {31'b0, wr_en}, 32'd0);
        chk("R10 reset wr_data", wr_data, 32'd0);
        chk("R10 reset flags", {30'b0, frame_start, frame_end}, 32'd0);
    endtask

    task automatic t_basic();
        setup(0, 0, 0, 0, 0);
        pix(8'hEE, 0, 0); pix(8'hEE, 0, 0); pix(8'hEE, 0, 1);
        four(32'h44332211);
        pix(8'hEE, 0, 1); pix(8'hEE, 0, 1);
        four(32'h88776655);
        pix(8'hEE, 0, 1); pix(8'hEE, 0, 0); pix(8'hEE, 0, 0);
        chk("R3 blanking dropped, word count", words.size(), 2);
        chk("R7 first word", words.size() > 0 ? words[0] : 32'hX, 32'h44332211);
        chk("R5 immediate second word", words.size() > 1 ? words[1] : 32'hX, 32'h88776655);
        chk("R9 frame_start count", fs_cnt, 1);
        chk("R8 frame_end count", fe_cnt, 1);
    endtask

    task automatic t_swap();
        setup(0, 0, 0, 0, 1);
        pix(8'hEE, 0, 0);
        four(32'h44332211);
        pix(8'hEE, 0, 0);
        chk("R7 swapped word", words.size() == 1 ? words[0] : 32'hX, 32'h11223344);
    endtask

    task automatic t_partial();
        setup(0, 0, 0, 0, 0);
        pix(8'hEE, 0, 0);
        four(32'h04030201);
        pix(8'h05, 1, 1); pix(8'h06, 1, 1);
        pix(8'hEE, 0, 1);
        chk("R6 no flush before frame end", words.size(), 1);
        pix(8'hEE, 0, 0); pix(8'hEE, 0, 0);
        chk("R8 padded flush count", words.size(), 2);
        chk("R8 padded word", words.size() > 1 ? words[1] : 32'hX, 32'h00000605);
        chk("R8 frame_end", fe_cnt, 1);
    endtask

    task automatic t_polarity();
        setup(0, 1, 1, 0, 0);
        pix(8'hEE, 0, 0);
        four(32'hD4C3B2A1);
        pix(8'hEE, 0, 1);
        pix(8'hEE, 0, 0);
        chk("R2 inverted sync count", words.size(), 1);
        chk("R2 inverted sync word", words.size() == 1 ? words[0] : 32'hX, 32'hD4C3B2A1);
    endtask

    task automatic t_fall();
        setup(1, 0, 0, 0, 0);
        pix(8'hEE, 0, 0);
        four(32'h697A8B9C);
        pix(8'hEE, 0, 0);
        chk("R1 falling edge word", words.size() == 1 ? words[0] : 32'hX, 32'h697A8B9C);
    endtask

    task automatic t_wait();
        setup(0, 0, 0, 1, 0);
        four(32'hF4F3F2F1);
        pix(8'hEE, 0, 0); pix(8'hEE, 0, 0);
        chk("R4 in-progress frame dropped", words.size(), 0);
        chk("R4 no frame_end for unarmed frame", fe_cnt, 0);
        four(32'h34333231);
        pix(8'hEE, 0, 0); pix(8'hEE, 0, 0);
        chk("R4 armed word", words.size() == 1 ? words[0] : 32'hX, 32'h34333231);
        chk("R4 frame_end after armed frame", fe_cnt, 1);
    endtask

    task automatic t_decim();
        setup(0, 0, 0, 0, 0);
        pix(8'hEE, 0, 0);
        for (int i = 1; i <= 4; i++) begin
            pix(8'(i), 1, 1);
            pix(8'hEE, 0, 1);
        end
        chk("R6 decimated word", words.size() == 1 ? words[0] : 32'hX, 32'h04030201);
        chk("R6 no frame_end on line toggle", fe_cnt, 0);
        pix(8'hEE, 0, 0);
    endtask

    task automatic t_disable();
        setup(0, 0, 0, 0, 0);
        pix(8'h77, 1, 1); pix(8'h78, 1, 1);
        cfg_enable = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 outputs idle when off", {29'b0, wr_en, frame_start, frame_end}, 32'd0);
        repeat (2) @(negedge clk);
        cfg_enable = 1'b1;
        four(32'h04030201);
        chk("R10 pending bytes discarded", words.size() == 1 ? words[0] : 32'hX, 32'h04030201);
        // arming is cleared by disable
        setup(0, 0, 0, 1, 0);
        pix(8'hEE, 0, 0);
        pix(8'h11, 1, 1);
        cfg_enable = 1'b0;
        repeat (4) @(negedge clk);
        words.delete();
        cfg_enable = 1'b1;
        four(32'h0D0C0B0A);
        chk("R10 arming cleared", words.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_swap();
        t_partial();
        t_polarity();
        t_fall();
        t_wait();
        t_decim();
        t_disable();
        summary();
        $finish;
    end
endmodule